// File: doc/BRIEF.md
# Extension State Dirty Tracker

This block keeps two 2-bit usage fields in a processor's status word: one for the floating-point register file and one for any additional extension state. Each field moves through four values (off, initial, clean, dirty). An operating system reads the fields on a context switch to decide whether a unit's registers must be saved. Software can load either field at any time. The hardware moves a field to dirty on its own when an instruction changes that unit's state.

While a field is off, the unit counts as disabled. Any instruction that touches its registers is flagged for a trap in the same cycle. The block also reduces both fields into a single summary bit, placed at the top of the status word, so that software can find out with one sign test whether any save is needed.

Top module: `xstate_tracker`

## Requirements
- R1: While reset is asserted and just after it, both fields read 0 (off), the summary bit is 0, and the status word is all zeros.
- R2: A software write loads the floating-point field from write-data bits 14:13 and the extension field from bits 16:15. The new values are visible on the outputs in the cycle after the write. All other write-data bits are ignored.
- R3: A state-modifying strobe for a unit whose field is 1 (initial) or 2 (clean) sets that field to 3 (dirty) in the next cycle.
- R4: A state-modifying strobe for a unit whose field is 0 (off) raises that unit's fault output in the same cycle and leaves the field at 0.
- R5: An access strobe raises the unit's fault output in the same cycle exactly when the unit's field is 0. The fault output is low whenever the unit is neither accessed nor modified.
- R6: An access strobe without a modify strobe never changes a field.
- R7: When a software write and a modify strobe occur in the same cycle, the written value wins.
- R8: The summary bit is 1 exactly when at least one of the two fields equals 3, and it follows the field outputs with no added delay.
- R9: The status word carries the floating-point field at bits 14:13, the extension field at bits 16:15 and the summary bit at bit XLEN-1. Every other bit is 0.
- R10: A field at 3 stays at 3 until software writes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_wr_en | input | 1 | Software write of the status word |
| sw_wr_data | input | XLEN | Write data; only bits 16:13 are used |
| fp_access | input | 1 | Instruction touches floating-point registers |
| fp_modify | input | 1 | Instruction changes floating-point state |
| ext_access | input | 1 | Instruction touches extension registers |
| ext_modify | input | 1 | Instruction changes extension state |
| fp_state | output | 2 | Floating-point field (0 off, 1 initial, 2 clean, 3 dirty) |
| ext_state | output | 2 | Extension field, same encoding |
| sum_dirty | output | 1 | Summary dirty bit |
| status_word | output | XLEN | Fields and summary placed at their status positions |
| fp_fault | output | 1 | Floating-point access while off |
| ext_fault | output | 1 | Extension access while off |

## Verification
A wrong field value shows on the field outputs in the very next cycle after the edge that stored it. It also reaches the summary bit and the status word at the same moment, because both are combinational views of the stored fields. A missed or spurious promotion is therefore visible one cycle after the modify strobe. A wrong off decision is visible without delay on the fault outputs, in the cycle of the access itself. For this reason the reference model is compared against every output in every cycle, so that a divergence is reported in the cycle it first appears.

// File: rtl/xst_pkg.sv
package xst_pkg;

  typedef enum logic [1:0] {
    XS_OFF   = 2'd0,
    XS_INIT  = 2'd1,
    XS_CLEAN = 2'd2,
    XS_DIRTY = 2'd3
  } xs_state_t;

  // Next value of one field: software write first, then hardware promotion.
  function automatic xs_state_t xs_next(xs_state_t cur, logic wr, logic [1:0] wval,
                                        logic modify);
    xs_state_t nxt;
    nxt = cur;
    if (wr) begin
      nxt = xs_state_t'(wval);
    end else if (modify && (cur == XS_INIT || cur == XS_CLEAN)) begin
      nxt = XS_DIRTY;
    end
    return nxt;
  endfunction

  // A disabled unit faults on any touch.
  function automatic logic xs_is_fault(xs_state_t cur, logic access, logic modify);
    return (access || modify) && (cur == XS_OFF);
  endfunction

endpackage

// File: rtl/xst_field.sv
module xst_field
  import xst_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wr_val,
  input  logic       access,
  input  logic       modify,
  output logic [1:0] state_o,
  output logic       fault_o,
  output logic       promote_o
);

  xs_state_t state_q;
  xs_state_t state_d;

  always_comb begin
    state_d = xs_next(state_q, wr_en, wr_val, modify);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= XS_OFF;
    end else begin
      state_q <= state_d;
    end
  end

  assign promote_o = !wr_en && modify && (state_q == XS_INIT || state_q == XS_CLEAN);
  assign fault_o   = xs_is_fault(state_q, access, modify);
  assign state_o   = state_q;

  assert_promote_R3: assert property (@(posedge clk) disable iff (!rst_n)
    promote_o |=> state_q == XS_DIRTY);

  assert_off_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && state_q == XS_OFF) |=> state_q == XS_OFF);

  assert_access_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !modify) |=> $stable(state_q));

  assert_sw_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> state_q == $past(wr_val));

  assert_dirty_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && state_q == XS_DIRTY) |=> state_q == XS_DIRTY);

endmodule

// File: rtl/xst_summary.sv
module xst_summary #(
  parameter int N_UNITS = 2
) (
  input  logic [2*N_UNITS-1:0] fields,
  output logic                 any_dirty
);

  logic [N_UNITS-1:0] unit_dirty;

  for (genvar g = 0; g < N_UNITS; g++) begin : g_unit
    assign unit_dirty[g] = &fields[2*g +: 2];
  end

  assign any_dirty = |unit_dirty;

endmodule

// File: rtl/xst_pack.sv
module xst_pack #(
  parameter int XLEN       = 64,
  parameter int FIELD_BASE = 13,
  parameter int N_UNITS    = 2
) (
  input  logic [2*N_UNITS-1:0] fields,
  input  logic                 any_dirty,
  output logic [XLEN-1:0]      word
);

  localparam int FieldTop = FIELD_BASE + 2*N_UNITS - 1;

  for (genvar b = 0; b < XLEN; b++) begin : g_bit
    if (b == XLEN-1) begin : g_sum
      assign word[b] = any_dirty;
    end else if (b >= FIELD_BASE && b <= FieldTop) begin : g_fld
      assign word[b] = fields[b-FIELD_BASE];
    end else begin : g_zero
      assign word[b] = 1'b0;
    end
  end

endmodule

// File: rtl/xstate_tracker.sv
module xstate_tracker #(
  parameter int XLEN       = 64,
  parameter int FIELD_BASE = 13
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sw_wr_en,
  input  logic [XLEN-1:0] sw_wr_data,
  input  logic            fp_access,
  input  logic            fp_modify,
  input  logic            ext_access,
  input  logic            ext_modify,
  output logic [1:0]      fp_state,
  output logic [1:0]      ext_state,
  output logic            sum_dirty,
  output logic [XLEN-1:0] status_word,
  output logic            fp_fault,
  output logic            ext_fault
);

  localparam int NUnits = 2;
  localparam int FieldW = 2 * NUnits;

  logic [NUnits-1:0] acc_v;
  logic [NUnits-1:0] mod_v;
  logic [NUnits-1:0] fault_v;
  logic [NUnits-1:0] promote_v;
  logic [FieldW-1:0] fields_v;
  logic [FieldW-1:0] wr_fields;

  assign acc_v     = {ext_access, fp_access};
  assign mod_v     = {ext_modify, fp_modify};
  assign wr_fields = sw_wr_data[FIELD_BASE +: FieldW];

  for (genvar u = 0; u < NUnits; u++) begin : g_field
    xst_field u_field (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (sw_wr_en),
      .wr_val    (wr_fields[2*u +: 2]),
      .access    (acc_v[u]),
      .modify    (mod_v[u]),
      .state_o   (fields_v[2*u +: 2]),
      .fault_o   (fault_v[u]),
      .promote_o (promote_v[u])
    );
  end

  xst_summary #(.N_UNITS(NUnits)) u_sum (
    .fields    (fields_v),
    .any_dirty (sum_dirty)
  );

  xst_pack #(.XLEN(XLEN), .FIELD_BASE(FIELD_BASE), .N_UNITS(NUnits)) u_pack (
    .fields    (fields_v),
    .any_dirty (sum_dirty),
    .word      (status_word)
  );

  assign fp_state  = fields_v[1:0];
  assign ext_state = fields_v[3:2];
  assign fp_fault  = fault_v[0];
  assign ext_fault = fault_v[1];

  assert_fault_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fp_fault |-> fp_state == 2'd0) and (ext_fault |-> ext_state == 2'd0));

  assert_fault_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!fp_access && !fp_modify) |-> !fp_fault);

  assert_summary_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sum_dirty == (fp_state == 2'd3 || ext_state == 2'd3));

  assert_promote_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sw_wr_en |-> $countones(promote_v) == 0);

endmodule

// File: tb/sim_xstate_tracker.sv
`timescale 1ns/1ps
module sim_xstate_tracker;

  localparam int XLEN = 64;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            sw_wr_en = 1'b0;
  logic [XLEN-1:0] sw_wr_data = '0;
  logic            fp_access = 1'b0;
  logic            fp_modify = 1'b0;
  logic            ext_access = 1'b0;
  logic            ext_modify = 1'b0;
  logic [1:0]      fp_state;
  logic [1:0]      ext_state;
  logic            sum_dirty;
  logic [XLEN-1:0] status_word;
  logic            fp_fault;
  logic            ext_fault;

  int tests = 0;
  int fails = 0;
  int m_fp  = 0;
  int m_ext = 0;

  always #2.5 clk = ~clk;

  xstate_tracker #(.XLEN(XLEN)) u0 (
    .clk(clk), .rst_n(rst_n), .sw_wr_en(sw_wr_en), .sw_wr_data(sw_wr_data),
    .fp_access(fp_access), .fp_modify(fp_modify),
    .ext_access(ext_access), .ext_modify(ext_modify),
    .fp_state(fp_state), .ext_state(ext_state), .sum_dirty(sum_dirty),
    .status_word(status_word), .fp_fault(fp_fault), .ext_fault(ext_fault)
  );

  task automatic check(input string req, input string what,
                       input logic [XLEN-1:0] got, input logic [XLEN-1:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    int s;
    logic [XLEN-1:0] w;
    s = (m_fp == 3 || m_ext == 3) ? 1 : 0;
    w = '0;
    w[14:13] = m_fp[1:0];
    w[16:15] = m_ext[1:0];
    w[XLEN-1] = s[0];
    check(tag, "fp_state", XLEN'(fp_state), XLEN'(m_fp));
    check(tag, "ext_state", XLEN'(ext_state), XLEN'(m_ext));
    check(tag, "fp_fault", XLEN'(fp_fault), XLEN'((fp_access || fp_modify) && m_fp == 0));
    check(tag, "ext_fault", XLEN'(ext_fault), XLEN'((ext_access || ext_modify) && m_ext == 0));
    check("R8", "sum_dirty", XLEN'(sum_dirty), XLEN'(s));
    check("R9", "status_word", status_word, w);
  endtask

  // One cycle: drive after the falling edge, compare, then advance the model at the rising edge.
  task automatic step(input bit wr, input int fp_v, input int ext_v,
                      input bit fa, input bit fm, input bit ea, input bit em,
                      input string tag);
    logic [XLEN-1:0] d;
    @(negedge clk);
    d = ~'0;
    d[14:13] = fp_v[1:0];
    d[16:15] = ext_v[1:0];
    sw_wr_en = wr; sw_wr_data = d;
    fp_access = fa; fp_modify = fm; ext_access = ea; ext_modify = em;
    #1;
    compare_all(tag);
    @(posedge clk);
    if (wr) begin
      m_fp = fp_v & 3; m_ext = ext_v & 3;
    end else begin
      if (fm && (m_fp == 1 || m_fp == 2)) m_fp = 3;
      if (em && (m_ext == 1 || m_ext == 2)) m_ext = 3;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int lfsr;
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare_all("R1");
    rst_n = 1'b1;
    step(0, 0, 0, 0, 0, 0, 0, "R1");
    step(0, 0, 0, 1, 1, 0, 0, "R4");
    step(0, 0, 0, 0, 0, 0, 1, "R4");
    step(0, 0, 0, 1, 0, 1, 0, "R5");
    step(1, 1, 2, 0, 0, 0, 0, "R2");
    step(0, 0, 0, 1, 0, 1, 0, "R6");
    step(0, 0, 0, 1, 0, 1, 0, "R5");
    step(0, 0, 0, 1, 1, 0, 0, "R3");
    step(0, 0, 0, 0, 0, 1, 1, "R3");
    step(0, 0, 0, 0, 0, 0, 0, "R10");
    step(0, 0, 0, 1, 1, 1, 1, "R10");
    step(1, 2, 1, 1, 1, 1, 1, "R7");
    step(1, 0, 3, 0, 0, 0, 0, "R2");
    step(0, 0, 0, 1, 0, 0, 0, "R5");
    step(1, 0, 0, 0, 0, 1, 1, "R7");
    lfsr = 32'h1ACE;
    for (int i = 0; i < 300; i++) begin
      lfsr = (lfsr << 1) ^ ((lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]) ? 1 : 0);
      step((lfsr[3:0] == 0), lfsr[5:4], lfsr[7:6], lfsr[8], lfsr[9], lfsr[10], lfsr[11], "R3");
    end
    @(negedge clk);
    rst_n = 1'b0;
    @(posedge clk);
    m_fp = 0; m_ext = 0;
    @(negedge clk);
    sw_wr_en = 0; fp_access = 0; fp_modify = 0; ext_access = 0; ext_modify = 0;
    #1;
    compare_all("R1");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule